// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

This block clocks a programmed number of 8-bit words out of and into an SPI serial link as master. A register decoder elsewhere on the chip writes a control word, a total burst length and a transmit length, and it loads bytes into a 64-entry transmit queue. When the start bit is written, the engine clocks the whole burst. The first bytes come from the transmit queue, as many as the transmit length gives. The rest of the burst sends zero bytes. Every byte shifted in is placed in a 64-entry receive queue, unless the drop option discards the bytes received while transmit data is still being sent.

The serial clock rate is set outside the block. An enable strobe `sck_en` marks each half period, and the engine toggles SCK once per strobe. The control word selects clock polarity, clock phase and bit order. When the burst ends, the start bit clears itself and a done flag is set in the status word. An interrupt line follows that flag through an enable mask. Software clears the flag by writing one to it. Both queue fill levels can be read from a status word.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `ctrl_q`, `status` and `fifo_status` all read 0, `irq` is low and `sck` is low.
- R2: A control write stores enable (bit 0), master (bit 1), CPHA (bit 2), CPOL (bit 3), LSB-first (bit 6) and drop-receive (bit 15), which read back on `ctrl_q`. The start bit (bit 10) is accepted only when the same write also sets bits 0 and 1. Otherwise the start bit is ignored and no burst begins.
- R3: Each queue holds 64 bytes, and a push into a full queue is ignored. `fifo_status` bits 6:0 give the receive fill level and bits 22:16 give the transmit fill level. The other bits read 0.
- R4: Writing 1 to bit 8 empties the transmit queue, and writing 1 to bit 9 empties the receive queue. Each of these bits reads 1 on `ctrl_q` for exactly one cycle after the write.
- R5: A burst clocks `burst_len` bytes. The first `tx_len` of them are taken from the transmit queue in push order, and each later byte is sent as 0x00.
- R6: Each received byte is pushed into the receive queue in arrival order. When bit 15 is set, the bytes received while transmit-queue bytes are being sent are discarded.
- R7: SCK idles at the CPOL level. Each byte takes 16 SCK edges, one for each `sck_en` strobe. With CPHA=0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R8: Bits go out and come in MSB first, or LSB first when bit 6 is set.
- R9: At the end of a burst, start bit 10 reads 0 and status bit 16 is set. `irq` is high exactly while status bit 16 and `int_en` bit 16 are both 1.
- R10: A status write with bit 16 set clears the done flag. A status write with bit 16 clear leaves it unchanged.
- R11: If the transmit queue is empty while transmit bytes are still owed, SCK holds its idle level and the burst does not complete. Once a byte is pushed, the burst resumes and sends the newly pushed byte.
- R12: A burst started with `burst_len` of 0 completes without any SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_en | input | 1 | Half-period strobe for SCK |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Control word readback |
| burst_len | input | 24 | Total bytes in a burst |
| tx_len | input | 24 | Bytes taken from the transmit queue |
| int_en | input | 32 | Interrupt enable mask (bit 16) |
| sta_wr | input | 1 | Status write strobe (write one to clear) |
| sta_wdata | input | 32 | Status write data |
| status | output | 32 | Status word, done flag in bit 16 |
| irq | output | 1 | Interrupt request |
| fifo_status | output | 32 | Queue fill levels |
| tx_push | input | 1 | Push into the transmit queue |
| tx_push_data | input | 8 | Byte to push |
| rx_pop | input | 1 | Pop the receive queue head |
| rx_pop_data | output | 8 | Receive queue head |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions take for granted that the queue reset bits are never written in two back-to-back cycles. They also assume that CPOL is not changed while a burst is running, since the idle-level check expects SCK to return to CPOL once the start bit is low. The bench writes the control word only through a task that holds the strobe for a single cycle with idle cycles around it. It changes the mode bits only while the engine is idle, and `sck_en` comes from a free-running divider that never runs faster than every other cycle, so the serial slave model has a full clock to react between edges.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    // control word bit positions
    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_MASTER = 1;
    localparam int unsigned CB_CPHA   = 2;
    localparam int unsigned CB_CPOL   = 3;
    localparam int unsigned CB_LSB    = 6;
    localparam int unsigned CB_TXRST  = 8;
    localparam int unsigned CB_RXRST  = 9;
    localparam int unsigned CB_GO     = 10;
    localparam int unsigned CB_DROP   = 15;

    // status and level field positions
    localparam int unsigned SB_DONE   = 16;
    localparam int unsigned LV_RX_LSB = 0;
    localparam int unsigned LV_TX_LSB = 16;

    localparam int unsigned BYTE_EDGES = 16;

    typedef struct packed {
        logic enable;
        logic master;
        logic cpha;
        logic cpol;
        logic lsb_first;
        logic drop_rx;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_DONE
    } eng_state_e;

    function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic bit_in,
                                            input logic lsb_first);
        return lsb_first ? {bit_in, cur[7:1]} : {cur[6:0], bit_in};
    endfunction

    function automatic logic [7:0] shift_out(input logic [7:0] cur, input logic lsb_first);
        return lsb_first ? {1'b0, cur[7:1]} : {cur[6:0], 1'b0};
    endfunction

endpackage

// File: rtl/sbe_fifo.sv
module sbe_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     level
);
    // DEPTH is a power of two so the pointers wrap on their own
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && (count != LW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            count <= count + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/sbe_shifter.sv
module sbe_shifter
    import spi_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_en,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int EW = $clog2(BYTE_EDGES);

    logic          active;
    logic [EW-1:0] edge_idx;
    logic [7:0]    tx_sr;
    logic [7:0]    rx_sr;
    logic [7:0]    rx_next;
    logic          sck_q;
    logic          leading;
    logic          sample_now;
    logic          shift_now;
    logic          last_edge;

    always_comb begin
        leading    = ~edge_idx[0];
        last_edge  = (edge_idx == EW'(BYTE_EDGES - 1));
        sample_now = cpha ? ~leading : leading;
        if (cpha) begin
            shift_now = leading && (edge_idx != '0);
        end else begin
            shift_now = ~leading && ~last_edge;
        end
        rx_next = sample_now ? shift_in(rx_sr, miso, lsb_first) : rx_sr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            edge_idx <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            rx_byte  <= '0;
            sck_q    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                sck_q <= cpol;
                if (load) begin
                    active   <= 1'b1;
                    tx_sr    <= load_data;
                    edge_idx <= '0;
                end
            end else if (sck_en) begin
                sck_q    <= ~sck_q;
                edge_idx <= edge_idx + 1'b1;
                rx_sr    <= rx_next;
                if (shift_now) begin
                    tx_sr <= shift_out(tx_sr, lsb_first);
                end
                if (last_edge) begin
                    active  <= 1'b0;
                    done    <= 1'b1;
                    rx_byte <= rx_next;
                end
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = lsb_first ? tx_sr[0] : tx_sr[7];

endmodule

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
    import spi_burst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] tx_len,
    input  logic             tx_empty,
    input  logic [7:0]       tx_head,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    output mode_t            mode,
    output logic             tx_clr,
    output logic             rx_clr,
    output logic             tx_pop,
    output logic             sh_load,
    output logic [7:0]       sh_data,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    output logic             burst_done,
    output logic [31:0]      ctrl_q
);
    eng_state_e       state;
    logic             go_q;
    logic [CNT_W-1:0] bytes_left;
    logic [CNT_W-1:0] tx_left;
    logic             from_tx;
    logic             start_ok;

    assign start_ok = ctrl_wr && ctrl_wdata[CB_GO] && ctrl_wdata[CB_EN] &&
                      ctrl_wdata[CB_MASTER];

    always_comb begin
        tx_pop     = 1'b0;
        sh_load    = 1'b0;
        sh_data    = 8'h00;
        rx_push    = 1'b0;
        rx_data    = sh_rx;
        burst_done = 1'b0;
        unique case (state)
            ST_FETCH: begin
                if (bytes_left != '0) begin
                    if (tx_left != '0) begin
                        if (!tx_empty) begin
                            tx_pop  = 1'b1;
                            sh_load = 1'b1;
                            sh_data = tx_head;
                        end
                    end else begin
                        sh_load = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    rx_push = !(mode.drop_rx && from_tx);
                end
            end
            ST_DONE: burst_done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            go_q       <= 1'b0;
            bytes_left <= '0;
            tx_left    <= '0;
            from_tx    <= 1'b0;
            mode       <= '0;
            tx_clr     <= 1'b0;
            rx_clr     <= 1'b0;
        end else begin
            tx_clr <= ctrl_wr && ctrl_wdata[CB_TXRST];
            rx_clr <= ctrl_wr && ctrl_wdata[CB_RXRST];
            if (ctrl_wr) begin
                mode.enable    <= ctrl_wdata[CB_EN];
                mode.master    <= ctrl_wdata[CB_MASTER];
                mode.cpha      <= ctrl_wdata[CB_CPHA];
                mode.cpol      <= ctrl_wdata[CB_CPOL];
                mode.lsb_first <= ctrl_wdata[CB_LSB];
                mode.drop_rx   <= ctrl_wdata[CB_DROP];
            end
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        go_q       <= 1'b1;
                        bytes_left <= burst_len;
                        tx_left    <= tx_len;
                        state      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (bytes_left == '0) begin
                        state <= ST_DONE;
                    end else if (sh_load) begin
                        from_tx <= (tx_left != '0);
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        bytes_left <= bytes_left - 1'b1;
                        if (from_tx) begin
                            tx_left <= tx_left - 1'b1;
                        end
                        state <= ST_FETCH;
                    end
                end
                ST_DONE: begin
                    go_q  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctrl_q            = '0;
        ctrl_q[CB_EN]     = mode.enable;
        ctrl_q[CB_MASTER] = mode.master;
        ctrl_q[CB_CPHA]   = mode.cpha;
        ctrl_q[CB_CPOL]   = mode.cpol;
        ctrl_q[CB_LSB]    = mode.lsb_first;
        ctrl_q[CB_TXRST]  = tx_clr;
        ctrl_q[CB_RXRST]  = rx_clr;
        ctrl_q[CB_GO]     = go_q;
        ctrl_q[CB_DROP]   = mode.drop_rx;
    end

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_en,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    output logic [31:0]      ctrl_q,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] tx_len,
    input  logic [31:0]      int_en,
    input  logic             sta_wr,
    input  logic [31:0]      sta_wdata,
    output logic [31:0]      status,
    output logic             irq,
    output logic [31:0]      fifo_status,
    input  logic             tx_push,
    input  logic [7:0]       tx_push_data,
    input  logic             rx_pop,
    output logic [7:0]       rx_pop_data,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

    mode_t            mode;
    logic             tx_clr, rx_clr, tx_pop;
    logic             sh_load, sh_done, rx_push, burst_done;
    logic [7:0]       sh_data, sh_rx, rx_data, tx_head;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             done_flag;

    sbe_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .head(tx_head), .level(tx_lvl)
    );

    sbe_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_push), .push_data(rx_data),
        .pop(rx_pop), .head(rx_pop_data), .level(rx_lvl)
    );

    sbe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .burst_len(burst_len), .tx_len(tx_len),
        .tx_empty(tx_lvl == '0), .tx_head(tx_head),
        .sh_done(sh_done), .sh_rx(sh_rx),
        .mode(mode), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_pop(tx_pop), .sh_load(sh_load), .sh_data(sh_data),
        .rx_push(rx_push), .rx_data(rx_data),
        .burst_done(burst_done), .ctrl_q(ctrl_q)
    );

    sbe_shifter u_shift (
        .clk(clk), .rst(rst), .sck_en(sck_en),
        .cpol(mode.cpol), .cpha(mode.cpha), .lsb_first(mode.lsb_first),
        .load(sh_load), .load_data(sh_data), .miso(miso),
        .done(sh_done), .rx_byte(sh_rx), .sck(sck), .mosi(mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (burst_done) begin
            done_flag <= 1'b1;
        end else if (sta_wr && sta_wdata[SB_DONE]) begin
            done_flag <= 1'b0;
        end
    end

    always_comb begin
        status                       = '0;
        status[SB_DONE]              = done_flag;
        fifo_status                  = '0;
        fifo_status[LV_RX_LSB +: LVL_W] = rx_lvl;
        fifo_status[LV_TX_LSB +: LVL_W] = tx_lvl;
    end

    assign irq = done_flag && int_en[SB_DONE];

endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_q,
    input logic [31:0] status,
    input logic        sta_wr,
    input logic [31:0] sta_wdata,
    input logic [31:0] fifo_status,
    input logic        sck
);
    localparam int LW = $clog2(DEPTH) + 1;

    assert_tx_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_status[16 +: LW] <= LW'(DEPTH));

    assert_rx_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_status[0 +: LW] <= LW'(DEPTH));

    assert_qrst_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[8] || ctrl_q[9]) |=> (!ctrl_q[8] && !ctrl_q[9]));

    assert_sck_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[10] && $past(!ctrl_q[10]) && $stable(ctrl_q[3])) |-> (sck == ctrl_q[3]));

    assert_start_clears_at_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(status[16]) |-> !ctrl_q[10]);

    assert_done_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        (sta_wr && sta_wdata[16] && !ctrl_q[10]) |=> !status[16]);

endmodule

bind spi_burst_engine sbe_checker #(.DEPTH(FIFO_DEPTH)) u_sbe_checker (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .status(status),
    .sta_wr(sta_wr), .sta_wdata(sta_wdata),
    .fifo_status(fifo_status), .sck(sck)
);

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_en = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_q;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic [31:0] int_en = 32'h0001_0000;
    logic        sta_wr = 1'b0;
    logic [31:0] sta_wdata = '0;
    logic [31:0] status;
    logic        irq;
    logic [31:0] fifo_status;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_push_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_pop_data;
    logic        sck, mosi, miso;

    spi_burst_engine i_spi_burst_engine (
        .clk(clk), .rst(rst), .sck_en(sck_en),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .burst_len(burst_len), .tx_len(tx_len), .int_en(int_en),
        .sta_wr(sta_wr), .sta_wdata(sta_wdata), .status(status), .irq(irq),
        .fifo_status(fifo_status), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // free-running half-period strobe, one of every three cycles
    int div = 0;
    always @(negedge clk) begin
        div    <= (div == 2) ? 0 : div + 1;
        sck_en <= (div == 2);
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // stimulus vectors: cpol cpha lsb drop | burst | txn | seed
    localparam int NV = 7;
    localparam logic [27:0] VECS [NV] = '{
        {4'b0000, 8'd4,  8'd4,  8'd11},
        {4'b0100, 8'd5,  8'd3,  8'd22},
        {4'b1010, 8'd6,  8'd6,  8'd33},
        {4'b1111, 8'd6,  8'd2,  8'd44},
        {4'b0011, 8'd3,  8'd3,  8'd55},
        {4'b1000, 8'd4,  8'd0,  8'd66},
        {4'b0110, 8'd63, 8'd63, 8'd77}
    };

    function automatic logic [7:0] tx_byte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    function automatic logic [7:0] sl_byte(input logic [7:0] seed, input int j);
        return (seed ^ 8'h5A) + 8'(j * 13);
    endfunction

    // serial slave model
    logic       tb_cpol = 0, tb_cpha = 0, tb_lsb = 0;
    logic [7:0] cur_seed = 0;
    int         slv_gen = 0, slv_seen = 0;
    int         se = 0, ecur = 0, cap_n = 0, s_idx = 0, tot_edges = 0;
    logic       prev_sck = 0;
    logic [7:0] cap = 0, s_sr = 0;
    logic [7:0] cap_arr [64];
    logic       smp;

    always @(negedge clk) begin
        if (slv_gen != slv_seen) begin
            slv_seen = slv_gen;
            se = 0; cap_n = 0; s_idx = 0; cap = 0;
            s_sr = sl_byte(cur_seed, 0);
            prev_sck = sck;
        end else if (!rst && sck !== prev_sck) begin
            prev_sck  = sck;
            tot_edges = tot_edges + 1;
            ecur = se;
            se = (se + 1) % 16;
            smp = tb_cpha ? (ecur % 2 == 1) : (ecur % 2 == 0);
            if (smp) cap = tb_lsb ? {mosi, cap[7:1]} : {cap[6:0], mosi};
            if (ecur == 15) begin
                if (cap_n < 64) cap_arr[cap_n] = cap;
                cap_n = cap_n + 1;
                s_idx = s_idx + 1;
                s_sr = sl_byte(cur_seed, s_idx);
            end else if (tb_cpha ? (ecur % 2 == 0 && ecur != 0) : (ecur % 2 == 1)) begin
                s_sr = tb_lsb ? (s_sr >> 1) : (s_sr << 1);
            end
        end
    end

    assign miso = tb_lsb ? s_sr[0] : s_sr[7];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic do_sta(input logic [31:0] v);
        @(negedge clk); sta_wr = 1'b1; sta_wdata = v;
        @(negedge clk); sta_wr = 1'b0; sta_wdata = '0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); tx_push = 1'b1; tx_push_data = b;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic wait_irq(input int limit);
        for (int k = 0; k < limit && !irq; k++) @(negedge clk);
    endtask

    function automatic logic [31:0] mode_word(input logic cpol, input logic cpha,
                                              input logic lsb, input logic drop);
        return 32'h3 | (32'(cpha) << 2) | (32'(cpol) << 3) | (32'(lsb) << 6) |
               (32'(drop) << 15);
    endfunction

    task automatic setup_mode(input logic cpol, input logic cpha, input logic lsb,
                              input logic drop, input logic [7:0] seed);
        tb_cpol = cpol; tb_cpha = cpha; tb_lsb = lsb; cur_seed = seed;
        do_ctrl(mode_word(cpol, cpha, lsb, drop) | 32'h300);
        repeat (3) @(negedge clk);
        slv_gen = slv_gen + 1;
        @(negedge clk);
    endtask

    initial begin
        logic [27:0] v;
        logic        drop;
        int          burst, txn, exp_rx, bad_b, fb_a, fb_e;
        logic [7:0]  seed;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ctrl_q == 0, "R1", "ctrl_q after reset", ctrl_q, 0);
        check(status == 0 && !irq, "R1", "status/irq after reset", status, 0);
        check(fifo_status == 0 && sck == 0, "R1", "levels/sck after reset", fifo_status, 0);

        // vector table
        for (int n = 0; n < NV; n++) begin
            v = VECS[n];
            drop = v[24]; burst = v[23:16]; txn = v[15:8]; seed = v[7:0];
            setup_mode(v[27], v[26], v[25], drop, seed);
            for (int i = 0; i < txn; i++) push(tx_byte(seed, i));
            burst_len = 24'(burst); tx_len = 24'(txn);
            do_ctrl(mode_word(v[27], v[26], v[25], drop) | 32'h400);
            wait_irq(40000);
            @(negedge clk);
            check(irq, "R9", "irq after burst", irq, 1);
            check(ctrl_q[10] == 0, "R9", "start bit self clears", ctrl_q[10], 0);
            check(cap_n == burst, "R7", "bytes seen by slave", cap_n, burst);
            bad_b = 0; fb_a = 0; fb_e = 0;
            for (int i = 0; i < burst && i < 64; i++) begin
                logic [7:0] e;
                e = (i < txn) ? tx_byte(seed, i) : 8'h00;
                if (cap_arr[i] !== e && bad_b == 0) begin fb_a = cap_arr[i]; fb_e = e; end
                if (cap_arr[i] !== e) bad_b++;
            end
            check(bad_b == 0, "R5", "mosi byte content (R8 order)", fb_a, fb_e);
            exp_rx = drop ? burst - txn : burst;
            check(fifo_status[6:0] == 7'(exp_rx), "R6", "rx fill level", fifo_status[6:0], exp_rx);
            bad_b = 0; fb_a = 0; fb_e = 0;
            for (int j = burst - exp_rx; j < burst; j++) begin
                if (rx_pop_data !== sl_byte(seed, j) && bad_b == 0) begin
                    fb_a = rx_pop_data; fb_e = sl_byte(seed, j);
                end
                if (rx_pop_data !== sl_byte(seed, j)) bad_b++;
                rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
            end
            check(bad_b == 0, "R6", "rx byte content (R8 order)", fb_a, fb_e);
            do_sta(32'h0001_0000);
            check(status[16] == 0 && !irq, "R10", "done flag w1c", status, 0);
        end

        // R2: start without enable is ignored, mode bits stored
        do_ctrl(32'h0000_844C);
        repeat (3) @(negedge clk);
        check(ctrl_q == 32'h0000_804C, "R2", "stored ctrl bits, start ignored", ctrl_q, 32'h804C);
        check(status[16] == 0, "R2", "no burst without enable", status, 0);

        // R12: zero-length burst
        setup_mode(0, 0, 0, 0, 8'h10);
        fb_a = tot_edges;
        burst_len = 0; tx_len = 0;
        do_ctrl(mode_word(0, 0, 0, 0) | 32'h400);
        repeat (6) @(negedge clk);
        check(status[16] == 1 && ctrl_q[10] == 0, "R12", "zero burst completes", status, 32'h10000);
        check(tot_edges == fb_a, "R12", "no sck edges", tot_edges, fb_a);

        // R10: writing 0 leaves flag; R9: mask gates irq
        do_sta(32'h0000_0000);
        check(status[16] == 1, "R10", "write 0 keeps flag", status[16], 1);
        int_en = 32'h0;
        @(negedge clk);
        check(!irq, "R9", "irq masked", irq, 0);
        int_en = 32'h0001_0000;
        @(negedge clk);
        check(irq, "R9", "irq unmasked", irq, 1);
        do_sta(32'hFFFF_FFFF);

        // R11: stall on empty tx queue
        setup_mode(1, 0, 0, 0, 8'h20);
        fb_a = tot_edges;
        burst_len = 2; tx_len = 2;
        do_ctrl(mode_word(1, 0, 0, 0) | 32'h400);
        repeat (200) @(negedge clk);
        check(status[16] == 0 && ctrl_q[10] == 1, "R11", "burst held while starved", status, 0);
        check(tot_edges == fb_a && sck == 1, "R11", "sck idle while starved", tot_edges - fb_a, 0);
        push(8'hC3); push(8'h3C);
        wait_irq(5000);
        @(negedge clk);
        check(irq && cap_n == 2, "R11", "burst resumes", cap_n, 2);
        check(cap_arr[0] == 8'hC3 && cap_arr[1] == 8'h3C, "R11", "fresh data sent",
              {cap_arr[0], cap_arr[1]}, 16'hC33C);
        do_sta(32'h0001_0000);

        // R3: capacity and ignored push; R4: queue reset
        setup_mode(0, 0, 0, 0, 8'h30);
        for (int i = 0; i < 65; i++) push(8'(i));
        check(fifo_status[22:16] == 7'd64, "R3", "tx level at full", fifo_status[22:16], 64);
        check(fifo_status[6:0] == 0 && fifo_status[31:23] == 0 && fifo_status[15:7] == 0,
              "R3", "other level bits", fifo_status, 32'h0040_0000);
        do_ctrl(32'h0000_0103);
        check(ctrl_q[8] == 1, "R4", "reset bit visible one cycle", ctrl_q[8], 1);
        @(negedge clk);
        check(ctrl_q[8] == 0, "R4", "reset bit self clears", ctrl_q[8], 0);
        check(fifo_status[22:16] == 0, "R4", "tx queue emptied", fifo_status[22:16], 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule